// File: doc/BRIEF.md
# Byte-Lane Peripheral Select and Data Steering

This block connects a 32-bit processor bus to a small set of 8-bit peripherals. Each bus cycle carries a doubleword address, four active-low byte enables, a flag that tells memory cycles from I/O cycles, a read/write flag and 32 bits of write data. From these the block works out which peripherals the cycle addresses and raises their selects. It hands each peripheral its byte of write data, and it gathers read bytes back onto the correct lanes of the 32-bit read bus.

Every peripheral answers in two places. One is its offset in the 64 KiB I/O space. The other is the same offset inside a 64 KiB window of memory space. The position of that window is a build-time parameter. Peripherals can be packed into one doubleword, with one peripheral per byte lane. In that layout the byte enables gate each select, so a write aimed at one lane never reaches a neighbour. Peripherals can also be spread one per doubleword. In that layout the byte enables play no part and every peripheral sits on the lowest lane.

The block also reproduces the way the processor drives write data. When only the upper two byte enables are active, the upper half of the write data is copied onto the lower half. The block registers its decode, so the selects and the steered data appear one clock after the bus cycle is presented.

Top module: `lane_io_sel`

## Requirements
- R1: In an I/O cycle (`bus_mio`=0), a peripheral is selected when the decoded bits of the cycle's 16-bit offset equal those of its table offset. Address bits 31..16 are ignored in I/O cycles.
- R2: In a memory cycle (`bus_mio`=1), a peripheral is selected only when address bits 31..16 equal bits 31..16 of `MEM_BASE`. Offset bits 15..0 are then decoded exactly as in an I/O cycle.
- R3: No select is raised when `bus_cyc` is low. No select is raised when the offset matches no table entry. No select is raised for a memory cycle outside the window.
- R4: In packed layout (`SPACED`=0), a peripheral at offset 4N+k (k = 0..3) uses data bits 8k+7..8k. It can be selected only while `bus_be_n[k]` is 0.
- R5: In packed layout, an access with exactly one byte enable active selects exactly one peripheral. A 16-bit access (enables 1..0 or 3..2) or a 32-bit access selects every peripheral on the enabled lanes.
- R6: `lane_wdata` is normally the registered write data. On a write where `bus_be_n[1:0]`=2'b11 and `bus_be_n[3:2]`≠2'b11, it instead carries bits 31..16 on both halves.
- R7: `dev_wdata` byte k holds byte L of `lane_wdata`, where L is peripheral k's lane: its offset bits 1..0 in packed layout, and 0 in spread layout.
- R8: On a read, `bus_rdata` holds each selected peripheral's `dev_rdata` byte on that peripheral's lane and zero on every other lane. `bus_rdata` is zero on writes and whenever no select is active. `dev_wr` is high only on a write that selects at least one peripheral.
- R9: Offset bits that are clear in `DEC_MASK` are not decoded, so offsets that differ only in those bits alias to the same peripheral.
- R10: In spread layout (`SPACED`=1), the byte enables have no effect on selection. Every peripheral exchanges data on bits 7..0.
- R11: Selects, steered data and the write flag are registered, and appear one clock after the bus inputs. Reset clears all selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 30 | Doubleword address, bits 31..2 |
| bus_be_n | input | 4 | Active-low byte enables, bit k for lane k |
| bus_mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_cyc | input | 1 | Cycle qualifier, decode only while high |
| bus_wdata | input | 32 | Write data as driven by the processor |
| bus_rdata | output | 32 | Merged read data |
| lane_wdata | output | 32 | Registered write data with upper-half copy applied |
| dev_sel | output | NDEV | One active-high select per peripheral |
| dev_wr | output | 1 | Write strobe for the selected peripherals |
| dev_wdata | output | NDEV*8 | Write byte for each peripheral |
| dev_rdata | input | NDEV*8 | Read byte from each peripheral |

## Verification
`dev_sel`, `dev_wr`, `lane_wdata` and `dev_wdata` come from one register stage, so each is due exactly one clock after a bus cycle is presented. `bus_rdata` follows the registered selects and the current peripheral read bytes with no further delay. The bench applies each stimulus on a falling edge and checks every output on the next falling edge, after exactly one rising edge. A second instance built in spread layout shares the same bus inputs and is checked at the same point.

// File: rtl/lane_pkg.sv
package lane_pkg;

  localparam int LANES = 4;

  // Write data as it appears on the bus: upper half copied down when only
  // the upper enables are active on a write.
  function automatic logic [31:0] bus_copy(input logic [31:0] d,
                                           input logic [3:0]  be_n,
                                           input logic        wr);
    if (wr && (be_n[1:0] == 2'b11) && (be_n[3:2] != 2'b11))
      return {d[31:16], d[31:16]};
    return d;
  endfunction

  // Lane a peripheral uses, given its table offset and layout.
  function automatic int lane_of(input logic [15:0] off, input bit spaced);
    return spaced ? 0 : int'(off[1:0]);
  endfunction

endpackage

// File: rtl/io_addr_match.sv
module io_addr_match #(
  parameter int                 NDEV     = 4,
  parameter logic [NDEV*16-1:0] DEV_TAB  = '0,
  parameter logic [31:0]        MEM_BASE = 32'hFFA0_0000,
  parameter logic [15:0]        DEC_MASK = 16'hFFFF,
  parameter bit                 SPACED   = 1'b0
) (
  input  logic [31:2]     addr,
  input  logic [3:0]      be_n,
  input  logic            mio,
  input  logic            cyc,
  output logic [NDEV-1:0] hit
);
  import lane_pkg::*;

  localparam logic [15:2] OFF_MASK = DEC_MASK[15:2];
  localparam logic [15:0] WIN_HI   = MEM_BASE[31:16];

  logic win_ok;
  assign win_ok = mio ? (addr[31:16] == WIN_HI) : 1'b1;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    localparam logic [15:0] ENTRY = DEV_TAB[k*16 +: 16];
    localparam int          LN    = lane_of(ENTRY, SPACED);
    logic off_ok;
    logic en_ok;
    assign off_ok = (((addr[15:2] ^ ENTRY[15:2]) & OFF_MASK) == '0);
    if (SPACED) begin : g_spread
      assign en_ok = 1'b1;
    end else begin : g_packed
      assign en_ok = ~be_n[LN];
    end
    assign hit[k] = cyc & win_ok & off_ok & en_ok;
  end

endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int                 NDEV    = 4,
  parameter logic [NDEV*16-1:0] DEV_TAB = '0,
  parameter bit                 SPACED  = 1'b0
) (
  input  logic [31:0]       wdata,
  output logic [NDEV*8-1:0] dev_wdata
);
  import lane_pkg::*;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    localparam int LN = lane_of(DEV_TAB[k*16 +: 16], SPACED);
    assign dev_wdata[k*8 +: 8] = wdata[LN*8 +: 8];
  end

endmodule

// File: rtl/read_merge.sv
module read_merge #(
  parameter int                 NDEV    = 4,
  parameter logic [NDEV*16-1:0] DEV_TAB = '0,
  parameter bit                 SPACED  = 1'b0
) (
  input  logic [NDEV-1:0]   sel,
  input  logic              rd_en,
  input  logic [NDEV*8-1:0] dev_rdata,
  output logic [31:0]       rdata
);
  import lane_pkg::*;

  logic [NDEV*32-1:0] part;

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    localparam int LN = lane_of(DEV_TAB[k*16 +: 16], SPACED);
    always_comb begin
      part[k*32 +: 32] = '0;
      if (rd_en && sel[k])
        part[k*32 + LN*8 +: 8] = dev_rdata[k*8 +: 8];
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NDEV; k++)
      rdata = rdata | part[k*32 +: 32];
  end

endmodule

// File: rtl/lane_io_sel.sv
module lane_io_sel #(
  parameter int                 NDEV     = 4,
  parameter logic [NDEV*16-1:0] DEV_TAB  = {16'h0303, 16'h0302, 16'h0301, 16'h0300},
  parameter logic [31:0]        MEM_BASE = 32'hFFA0_0000,
  parameter logic [15:0]        DEC_MASK = 16'h0FFF,
  parameter bit                 SPACED   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:2]       bus_addr,
  input  logic [3:0]        bus_be_n,
  input  logic              bus_mio,
  input  logic              bus_wr,
  input  logic              bus_cyc,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [31:0]       lane_wdata,
  output logic [NDEV-1:0]   dev_sel,
  output logic              dev_wr,
  output logic [NDEV*8-1:0] dev_wdata,
  input  logic [NDEV*8-1:0] dev_rdata
);
  import lane_pkg::*;

  logic [NDEV-1:0] hit;
  logic [NDEV-1:0] sel_q;
  logic            wr_q;
  logic [31:0]     wdata_q;

  io_addr_match #(
    .NDEV(NDEV), .DEV_TAB(DEV_TAB), .MEM_BASE(MEM_BASE),
    .DEC_MASK(DEC_MASK), .SPACED(SPACED)
  ) u_match (
    .addr(bus_addr), .be_n(bus_be_n), .mio(bus_mio),
    .cyc(bus_cyc), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      sel_q   <= hit;
      wr_q    <= bus_wr;
      wdata_q <= bus_copy(bus_wdata, bus_be_n, bus_wr);
    end
  end

  lane_steer #(
    .NDEV(NDEV), .DEV_TAB(DEV_TAB), .SPACED(SPACED)
  ) u_steer (
    .wdata(wdata_q), .dev_wdata(dev_wdata)
  );

  read_merge #(
    .NDEV(NDEV), .DEV_TAB(DEV_TAB), .SPACED(SPACED)
  ) u_merge (
    .sel(sel_q), .rd_en(~wr_q), .dev_rdata(dev_rdata), .rdata(bus_rdata)
  );

  assign dev_sel    = sel_q;
  assign dev_wr     = wr_q & (|sel_q);
  assign lane_wdata = wdata_q;

endmodule

// File: rtl/lane_io_sel_chk.sv
module lane_io_sel_chk #(
  parameter int                 NDEV     = 4,
  parameter logic [NDEV*16-1:0] DEV_TAB  = '0,
  parameter logic [31:0]        MEM_BASE = 32'hFFA0_0000,
  parameter bit                 SPACED   = 1'b0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [31:2]     bus_addr,
  input logic [3:0]      bus_be_n,
  input logic            bus_mio,
  input logic            bus_wr,
  input logic            bus_cyc,
  input logic [31:0]     bus_rdata,
  input logic [31:0]     lane_wdata,
  input logic [NDEV-1:0] dev_sel,
  input logic            dev_wr
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  // R3: an unqualified cycle never selects anything
  a_r3_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(bus_cyc) |-> dev_sel == '0);

  // R2: a select from a memory cycle implies the window matched
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && (dev_sel != '0) && $past(bus_mio)
      |-> $past(bus_addr[31:16]) == MEM_BASE[31:16]);

  // R6: upper-half copy on upper-only writes
  a_r6_upper_copy: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(bus_wr && bus_be_n[1:0] == 2'b11 && bus_be_n[3:2] != 2'b11)
      |-> lane_wdata[15:0] == lane_wdata[31:16]);

  // R8: read bus quiet without a select; write strobe needs a select
  a_r8_quiet_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel == '0 |-> bus_rdata == '0);
  a_r8_wr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> dev_sel != '0);

  if (!SPACED) begin : g_packed
    // R5: single-enable access selects at most one peripheral
    a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past($countones(~bus_be_n) == 1) |-> $onehot0(dev_sel));
    for (genvar k = 0; k < NDEV; k++) begin : g_dev
      localparam int LN = int'(DEV_TAB[k*16 +: 2]);
      // R4: select only with its own lane enabled
      a_r4_lane_guard: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && dev_sel[k] |-> !$past(bus_be_n[LN]));
    end
  end

endmodule

bind lane_io_sel lane_io_sel_chk #(
  .NDEV(NDEV), .DEV_TAB(DEV_TAB), .MEM_BASE(MEM_BASE), .SPACED(SPACED)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
  .bus_mio(bus_mio), .bus_wr(bus_wr), .bus_cyc(bus_cyc),
  .bus_rdata(bus_rdata), .lane_wdata(lane_wdata), .dev_sel(dev_sel),
  .dev_wr(dev_wr)
);

// File: tb/sim_lane_io_sel.sv
`timescale 1ns/1ps
module sim_lane_io_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:2] bus_addr = '0;
  logic [3:0]  bus_be_n = 4'hF;
  logic        bus_mio = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_cyc = 1'b0;
  logic [31:0] bus_wdata = '0;

  logic [31:0] rd0, lw0, rd1, lw1;
  logic [3:0]  sel0;
  logic [1:0]  sel1;
  logic        wr0, wr1;
  logic [31:0] dwd0;
  logic [15:0] dwd1;
  logic [31:0] drd0 = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
  logic [15:0] drd1 = {8'h5B, 8'h5A};

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  lane_io_sel u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_mio(bus_mio), .bus_wr(bus_wr), .bus_cyc(bus_cyc),
    .bus_wdata(bus_wdata), .bus_rdata(rd0), .lane_wdata(lw0),
    .dev_sel(sel0), .dev_wr(wr0), .dev_wdata(dwd0), .dev_rdata(drd0)
  );

  lane_io_sel #(
    .NDEV(2), .DEV_TAB({16'h0314, 16'h0310}), .MEM_BASE(32'hFFA0_0000),
    .DEC_MASK(16'hFFFF), .SPACED(1'b1)
  ) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_mio(bus_mio), .bus_wr(bus_wr), .bus_cyc(bus_cyc),
    .bus_wdata(bus_wdata), .bus_rdata(rd1), .lane_wdata(lw1),
    .dev_sel(sel1), .dev_wr(wr1), .dev_wdata(dwd1), .dev_rdata(drd1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] offs [5];
    offs[0] = 16'h0300; offs[1] = 16'h1300; offs[2] = 16'h0304;
    offs[3] = 16'h0310; offs[4] = 16'h0314;

    repeat (3) @(negedge clk);
    chk("R11 reset sel", {28'd0, sel0}, 32'd0);
    chk("R11 reset rdata", rd0, 32'd0);
    rst_n = 1'b1;

    // R3: cycle qualifier low on a matching address
    @(negedge clk);
    bus_addr = {16'h0000, 14'(16'h0300 >> 2)}; bus_be_n = 4'h0; bus_cyc = 1'b0;
    @(negedge clk);
    chk("R3 cyc low u0", {28'd0, sel0}, 32'd0);
    chk("R3 cyc low u1", {30'd0, sel1}, 32'd0);

    for (int sp = 0; sp < 3; sp++) begin
      for (int oi = 0; oi < 5; oi++) begin
        for (int w = 0; w < 2; w++) begin
          for (int be = 0; be < 16; be++) begin
            logic [15:0] off, hi;
            logic        win, h0, dup;
            logic [3:0]  e0;
            logic [1:0]  e1;
            logic [31:0] wd, el, er0, er1;
            off = offs[oi];
            hi  = (sp == 0) ? 16'h0000 : (sp == 1) ? 16'hFFA0 : 16'h1234;
            wd  = 32'hC4B3_A291 ^ (32'(be) * 32'h0101_0101) ^ (32'(oi) << 8);
            @(negedge clk);
            bus_cyc = 1'b1; bus_mio = (sp != 0); bus_wr = w[0];
            bus_be_n = be[3:0]; bus_addr = {hi, off[15:2]}; bus_wdata = wd;
            // expected values from the requirements
            win = (sp != 2);
            h0  = win && ((off & 16'h0FFC) == 16'h0300);
            for (int k = 0; k < 4; k++) e0[k] = h0 && !be[k];
            for (int k = 0; k < 2; k++)
              e1[k] = win && ((off & 16'hFFFC) == (16'h0310 + 16'(4*k)));
            dup = w[0] && (be[1:0] == 2'b11) && (be[3:2] != 2'b11);
            el  = dup ? {wd[31:16], wd[31:16]} : wd;
            er0 = '0;
            if (!w[0]) for (int k = 0; k < 4; k++) if (e0[k]) er0[k*8 +: 8] = 8'hA0 + 8'(k);
            er1 = '0;
            if (!w[0]) begin
              if (e1[0]) er1[7:0] = er1[7:0] | 8'h5A;
              if (e1[1]) er1[7:0] = er1[7:0] | 8'h5B;
            end
            @(negedge clk);
            if (sp == 0) chk(oi == 1 ? "R9 alias sel" : "R1 io sel", {28'd0, sel0}, {28'd0, e0});
            else if (sp == 1) chk("R2 window sel", {28'd0, sel0}, {28'd0, e0});
            else chk("R3 outside window", {28'd0, sel0}, {28'd0, e0});
            if (h0 && $countones(~be[3:0]) == 1)
              chk("R5 single lane", 32'($countones(sel0)), 32'd1);
            else if (h0) chk("R4 lane guard", {28'd0, sel0}, {28'd0, ~be[3:0]});
            chk("R6 lane wdata", lw0, el);
            chk("R7 dev wdata", dwd0, el);
            chk("R8 rdata", rd0, er0);
            chk("R8 dev_wr", {31'd0, wr0}, {31'd0, w[0] && (e0 != 0)});
            chk("R10 spread sel", {30'd0, sel1}, {30'd0, e1});
            chk("R10 spread wdata", {16'd0, dwd1}, {16'd0, el[7:0], el[7:0]});
            chk("R10 spread rdata", rd1, er1);
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule